// File: doc/BRIEF.md
# Parallel EEPROM Write-Cycle Controller

This block is the control side of a byte-wide nonvolatile memory of 2048 bytes. A register array stands in for the cells. The block decodes three active-low strobes: select, read enable and write enable. A falling edge of the write strobe, while the part is selected and reads are off, starts a self-timed program cycle. On that edge the address and data are latched, so the host may change the bus while the cycle runs.

Each program cycle has two phases. At its midpoint the target byte is cleared to all ones. At its end the latched value is written. While the cycle runs, a read returns a polling byte: the top bit is the complement of the top bit of the byte being written, and the lower bits come from the array byte at the current address. When the top bit reads true again, the write has completed.

Writes are locked out while the write-protect input is high or the supply-valid input is low. The bus is split into an input, an output and a drive-enable, which together make up the bidirectional data pins.

Top module: `peep_ctrl`

## Requirements
- R1: After reset busy_o is 0, drive_o is 0, and every byte reads 8'hFF.
- R2: A write is accepted only on the clock where wr_en_ni is sampled low after having been high, with sel_ni low, rd_en_ni high, busy_o low, wp_i low and pwr_ok_i high. Holding wr_en_ni low does not start a second cycle.
- R3: The address and data are captured when a write is accepted. Later changes on addr_i or data_i do not alter the byte that is written or where it is written.
- R4: busy_o rises on the clock edge that accepts the write and stays high for exactly CYC_LEN clock edges.
- R5: CYC_LEN/2 edges after acceptance the target byte is cleared to 8'hFF. The latched data is written on the final edge of the cycle.
- R6: While busy_o is high, data_o[7] is the complement of bit 7 of the latched data, and data_o[6:0] is bits 6:0 of the array byte at addr_i.
- R7: Falling edges on wr_en_ni while busy_o is high are ignored.
- R8: With wp_i high no write is accepted.
- R9: With pwr_ok_i low no write is accepted.
- R10: drive_o is 1 only when sel_ni and rd_en_ni are low and wr_en_ni is high.
- R11: When idle, data_o is the stored byte at addr_i.
- R12: A write strobe that arrives while rd_en_ni is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Device select, active low |
| rd_en_ni | input | 1 | Read/output enable, active low |
| wr_en_ni | input | 1 | Write strobe, active low |
| addr_i | input | 11 | Byte address |
| data_i | input | 8 | Write data from the bus |
| wp_i | input | 1 | Hardware write protect, high blocks writes |
| pwr_ok_i | input | 1 | Supply valid, low blocks writes |
| data_o | output | 8 | Read data or polling byte |
| drive_o | output | 1 | Bus drive enable for data_o |
| busy_o | output | 1 | High while a program cycle runs |

## Verification
A polling read and the internal clear step can fall on the same clock. The bench starts a write of 8'h35 to a byte that holds 8'h00 and then reads that address at the edge before the clear and at the edge after it. The polling byte must move from 8'h80 to 8'hFF at exactly the midpoint, with bit 7 inverted the whole time. A second write strobe pulsed mid-cycle and a strobe held low past the end of a cycle test whether an acceptance can overlap a running cycle or follow straight after one. In both cases busy_o and a readback of both addresses show the outcome.

// File: rtl/peep_pkg.sv
package peep_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG} phase_e;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/peep_strobe_dec.sv
module peep_strobe_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic rd_en_ni,
  input  logic wr_en_ni,
  input  logic busy_i,
  input  logic wp_i,
  input  logic pwr_ok_i,
  output logic accept_o,
  output logic drive_o
);
  logic wr_prev_q;
  logic wr_act, sel_act, rd_act, lock;

  assign wr_act  = ~wr_en_ni;
  assign sel_act = ~sel_ni;
  assign rd_act  = ~rd_en_ni;
  assign lock    = wp_i | ~pwr_ok_i | busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_prev_q <= 1'b0;
    else         wr_prev_q <= wr_act;
  end

  // edge of the write strobe only
  assign accept_o = wr_act & ~wr_prev_q & sel_act & ~rd_act & ~lock;
  assign drive_o  = sel_act & rd_act & ~wr_act;
endmodule

// File: rtl/peep_prog_timer.sv
module peep_prog_timer
  import peep_pkg::*;
#(
  parameter int unsigned CYC_LEN = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic busy_o,
  output logic erase_o,
  output logic commit_o
);
  localparam int unsigned HALF  = CYC_LEN / 2;
  localparam int unsigned REST  = CYC_LEN - HALF;
  localparam int unsigned LOG_W = $clog2(CYC_LEN + 1);
  localparam int unsigned CNT_W = (LOG_W > 16) ? LOG_W : 16;
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] REST_END = CNT_W'(REST - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign erase_o  = (phase_q == PH_ERASE) && (cnt_q == HALF_END);
  assign commit_o = (phase_q == PH_PROG)  && (cnt_q == REST_END);
  assign busy_o   = (phase_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept_i) begin
          phase_q <= PH_ERASE;
          cnt_q   <= '0;
        end
        PH_ERASE: if (erase_o) begin
          phase_q <= PH_PROG;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_PROG: if (commit_o) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  a_r4_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PROG) |-> ($past(phase_q) == PH_ERASE || $past(phase_q) == PH_PROG));
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ERASE) |-> (cnt_q <= HALF_END));
  a_r5_clear_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_PROG) |-> $past(erase_o));
endmodule

// File: rtl/peep_byte_array.sv
module peep_byte_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/peep_ctrl.sv
module peep_ctrl
  import peep_pkg::*;
#(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CYC_LEN = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              rd_en_ni,
  input  logic              wr_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wp_i,
  input  logic              pwr_ok_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o,
  output logic              busy_o
);
  logic              accept, erase, commit;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_data_q;
  logic              arr_we;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;

  peep_strobe_dec u_dec (
    .clk_i, .rst_ni, .sel_ni, .rd_en_ni, .wr_en_ni,
    .busy_i(busy_o), .wp_i, .pwr_ok_i,
    .accept_o(accept), .drive_o(drive_o)
  );

  peep_prog_timer #(.CYC_LEN(CYC_LEN)) u_tmr (
    .clk_i, .rst_ni, .accept_i(accept),
    .busy_o(busy_o), .erase_o(erase), .commit_o(commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else if (accept) begin
      lat_addr_q <= addr_i;
      lat_data_q <= data_i;
    end
  end

  assign arr_we    = erase | commit;
  assign arr_wdata = erase ? DATA_W'(ERASED_BYTE) : lat_data_q;

  peep_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk_i, .rst_ni, .we_i(arr_we), .waddr_i(lat_addr_q),
    .wdata_i(arr_wdata), .raddr_i(addr_i), .rdata_o(arr_rdata)
  );

  // polling: inverted top bit while the cycle runs
  assign data_o = busy_o ? {~lat_data_q[DATA_W-1], arr_rdata[DATA_W-2:0]} : arr_rdata;

  a_r3_latch_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(lat_addr_q) && $stable(lat_data_q)));
  a_r8_wp_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wp_i) |=> !busy_o);
  a_r9_pwr_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !pwr_ok_i) |=> !busy_o);
  a_r12_rd_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !rd_en_ni) |=> !busy_o);
  a_r10_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_ni) |-> !drive_o);
endmodule

// File: tb/sim_peep_ctrl.sv
module sim_peep_ctrl;
  localparam int CLK_PER = 10;
  localparam int CYC = 20;
  localparam int HALF = CYC / 2;
  localparam logic [18:0] VEC [6] = '{
    {11'h000, 8'hA5}, {11'h7FF, 8'h3C}, {11'h123, 8'h00},
    {11'h400, 8'hFF}, {11'h2AA, 8'h81}, {11'h555, 8'h7E}};

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, rd_n = 1, wr_n = 1, wp = 0, pwr_ok = 1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0, dout;
  logic drive, busy;
  int total = 0, bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  peep_ctrl #(.CYC_LEN(CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .rd_en_ni(rd_n), .wr_en_ni(wr_n),
    .addr_i(addr), .data_i(din), .wp_i(wp), .pwr_ok_i(pwr_ok),
    .data_o(dout), .drive_o(drive), .busy_o(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] v);
    addr = a; sel_n = 0; rd_n = 0; #1;
    v = dout;
    rd_n = 1; sel_n = 1; #1;
  endtask

  // returns at the negedge one clock after the accepting edge
  task automatic start_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; sel_n = 0; wr_n = 0;
    @(negedge clk); wr_n = 1; sel_n = 1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * CYC && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(drive == 0, "R1 drive", drive, 0);
    rd(11'h005, v); chk(v == 8'hFF, "R1 erased", v, 8'hFF);

    // table: write then read back
    for (int k = 0; k < 6; k++) begin
      start_write(VEC[k][18:8], VEC[k][7:0]);
      chk(busy == 1, "R2 accept", busy, 1);
      wait_idle();
      @(negedge clk);
      rd(VEC[k][18:8], v); chk(v == VEC[k][7:0], "R11 readback", v, VEC[k][7:0]);
    end

    // R4/R5/R6/R3 on byte 0x123 holding 0x00
    start_write(11'h123, 8'h35);
    chk(busy == 1, "R4 busy rise", busy, 1);
    rd(11'h123, v); chk(v == 8'h80, "R6 polling", v, 8'h80);
    addr = 11'h124; din = 8'hEE;
    repeat (HALF - 1) @(negedge clk);
    rd(11'h123, v); chk(v == 8'h80, "R5 before clear", v, 8'h80);
    @(negedge clk);
    rd(11'h123, v); chk(v == 8'hFF, "R5 cleared", v, 8'hFF);
    din = 8'h5A;
    repeat (CYC - HALF - 1) @(negedge clk);
    chk(busy == 1, "R4 last busy", busy, 1);
    @(negedge clk);
    chk(busy == 0, "R4 busy end", busy, 0);
    rd(11'h123, v); chk(v == 8'h35, "R3 latched data", v, 8'h35);
    rd(11'h124, v); chk(v == 8'hFF, "R3 latched addr", v, 8'hFF);

    // R7: strobe during busy ignored
    start_write(11'h010, 8'h11);
    @(negedge clk); addr = 11'h011; din = 8'h22; sel_n = 0; wr_n = 0;
    @(negedge clk); wr_n = 1; sel_n = 1;
    wait_idle(); @(negedge clk);
    rd(11'h011, v); chk(v == 8'hFF, "R7 ignored", v, 8'hFF);
    rd(11'h010, v); chk(v == 8'h11, "R7 first kept", v, 8'h11);

    // R2: held strobe does not restart
    @(negedge clk); addr = 11'h020; din = 8'h44; sel_n = 0; wr_n = 0;
    repeat (CYC + 3) @(negedge clk);
    chk(busy == 0, "R2 no restart", busy, 0);
    wr_n = 1; sel_n = 1;
    rd(11'h020, v); chk(v == 8'h44, "R2 held write", v, 8'h44);

    // R8 write protect
    wp = 1; start_write(11'h030, 8'h12);
    chk(busy == 0, "R8 wp busy", busy, 0);
    wp = 0; rd(11'h030, v); chk(v == 8'hFF, "R8 wp data", v, 8'hFF);

    // R9 supply low
    pwr_ok = 0; start_write(11'h031, 8'h34);
    chk(busy == 0, "R9 pwr busy", busy, 0);
    pwr_ok = 1; rd(11'h031, v); chk(v == 8'hFF, "R9 pwr data", v, 8'hFF);

    // R12 write while reading
    @(negedge clk); addr = 11'h032; din = 8'h56; sel_n = 0; rd_n = 0; wr_n = 0;
    @(negedge clk); wr_n = 1; rd_n = 1; sel_n = 1;
    chk(busy == 0, "R12 rd busy", busy, 0);
    rd(11'h032, v); chk(v == 8'hFF, "R12 rd data", v, 8'hFF);

    // R10 bus drive
    @(negedge clk); sel_n = 0; rd_n = 0; #1;
    chk(drive == 1, "R10 drive on", drive, 1);
    sel_n = 1; #1;
    chk(drive == 0, "R10 unselected", drive, 0);
    sel_n = 0; rd_n = 1; #1;
    chk(drive == 0, "R10 no rd", drive, 0);
    sel_n = 1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule